// File: doc/BRIEF.md
# DRAM Activation Throttle Controller

This block caps the number of row activations that one memory branch may issue within a fixed, free-running throttle window. It counts the activations that it accepts. It compares that count against a limit taken from one of three programmable levels: low, mid and high. A two-bit temperature range code, a global-throttle request, a mode bit and a hunt-enable bit decide which level applies. When the count reaches the limit, the block withdraws its activation grant until the window rolls over. During that blocked time it also drives the clock-enable pin low, so that the DRAM can idle.

Lowering clock-enable costs time at both ends. The DRAM needs a minimum low time, and it needs a gap after clock-enable returns high before the next command. For this reason the block does not drop clock-enable when throttling begins too close to the window end, and it always raises clock-enable a few cycles before the boundary. Refresh slots that fall due while activations are blocked are not lost. The block records them, up to two, and requests them from the scheduler as soon as the block is no longer throttled. Each acknowledged request retires one of them.

Top module: `act_throttle`

## Requirements
- R1: The window is a free-running counter of WIN_LEN (default 1344) cycles. Position 0 is the first cycle after reset is released, and the remaining count is WIN_LEN-1 minus the position. The accepted-activation count returns to zero on the edge that ends the cycle with remaining 0.
- R2: The effective limit is the selected 8-bit level register times 4. `act_ok` is high exactly while the accepted count is below that limit, so a register value of 0 blocks the whole window.
- R3: With `hunt_en`=0 the temperature code has no effect. `stat_lvl` is 1 (mid) when `gbl_req` is high and 0 (low) when it is low.
- R4: With `hunt_en`=1 the temperature code `temp_rng` means: 00 below Tlow, 01 between Tlow and Tmid, 1x above Tmid. Code 1x with `mode_hi`=1 selects level 2 (high), and this wins over `gbl_req`. Otherwise code 01, code 1x or `gbl_req` selects mid. Anything else selects low.
- R5: `gbl_req` acts on the level and the limit in the same cycle. `stat_gbl` shows its value from the previous cycle.
- R6: If the block is throttled in a cycle whose remaining count is at least CKE_LAT+6 (default 8), `cke` is low from the next cycle on. It stays low while the throttle holds and the remaining count is above 3.
- R7: A throttle first seen in a cycle whose remaining count is below CKE_LAT+6 leaves `cke` high for the rest of that window.
- R8: `cke` is high in every cycle whose remaining count is 2 or less, and it is high whenever the block was not throttled in the previous cycle.
- R9: Each `ref_due` pulse in a throttled cycle adds one pending refresh, saturating at 2. `ref_req` is high while refreshes are pending and the block is not throttled. Each cycle with both `ref_ack` and `ref_req` high retires one.
- R10: A `ref_due` pulse in a cycle that is not throttled adds no pending refresh. `ref_ack` without `ref_req` changes nothing.
- R11: `stat_thr` equals the inverse of `act_ok` in every cycle.
- R12: An `act_strobe` while `act_ok` is low is not counted. Raising the limit later in the same window reopens the grant at the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_strobe | input | 1 | Scheduler issues a row activation this cycle |
| ref_due | input | 1 | A refresh slot falls due this cycle |
| ref_ack | input | 1 | Scheduler issues the requested replay refresh |
| temp_rng | input | 2 | Temperature range code |
| gbl_req | input | 1 | Global-throttle request, unregistered |
| mode_hi | input | 1 | Enables the high level above Tmid |
| hunt_en | input | 1 | Lets temperature steer the level |
| lim_low | input | 8 | Low level, in units of 4 activations |
| lim_mid | input | 8 | Mid level, in units of 4 activations |
| lim_high | input | 8 | High level, in units of 4 activations |
| act_ok | output | 1 | Activations are permitted |
| cke | output | 1 | Clock-enable to the DRAM |
| ref_req | output | 1 | Replay refresh requested |
| stat_lvl | output | 2 | Level in use (0 low, 1 mid, 2 high) |
| stat_thr | output | 1 | Branch is throttled |
| stat_gbl | output | 1 | Registered copy of the global request |

## Verification
The window rollover can fall in the same cycle as an activation strobe or a refresh-due pulse. A refresh due on the last cycle of a fully blocked window must still be recorded, and it must then be requested in the first cycle of the next window. One window in four runs with a zero limit and places a due pulse on its final cycle. Random windows also place activation strobes on the rollover cycle. A cycle-level reference model in the bench, built from the requirements, judges every output on every cycle across the boundary.

// File: rtl/act_throttle_pkg.sv
package act_throttle_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'd0,
      LVL_MID  = 2'd1,
      LVL_HIGH = 2'd2
   } thr_lvl_e;

   localparam logic [1:0] TEMP_COOL = 2'b00;
endpackage

// File: rtl/act_thr_window.sv
module act_thr_window #(
   parameter int WIN_LEN = 1344,
   localparam int POS_W = $clog2(WIN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [POS_W-1:0] pos,
   output logic             last
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

   assign last = (pos == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (last) pos <= '0;
      else           pos <= pos + 1'b1;
   end
endmodule

// File: rtl/act_thr_level_sel.sv
module act_thr_level_sel
   import act_throttle_pkg::*;
(
   input  logic [1:0] temp_rng,
   input  logic       gbl_req,
   input  logic       mode_hi,
   input  logic       hunt_en,
   output thr_lvl_e   lvl
);
   always_comb begin
      if (!hunt_en)
         lvl = gbl_req ? LVL_MID : LVL_LOW;
      else if (temp_rng[1] && mode_hi)
         lvl = LVL_HIGH;
      else if (temp_rng != TEMP_COOL || gbl_req)
         lvl = LVL_MID;
      else
         lvl = LVL_LOW;
   end
endmodule

// File: rtl/act_thr_refresh.sv
module act_thr_refresh #(
   parameter int MAX_PEND = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic throttled,
   input  logic ref_due,
   input  logic ref_ack,
   output logic ref_req
);
   generate
      if (MAX_PEND == 1) begin : g_flag
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  pend_q <= 1'b0;
            else if (throttled && ref_due) pend_q <= 1'b1;
            else if (ref_req && ref_ack) pend_q <= 1'b0;
         end
         assign ref_req = pend_q && !throttled;
      end else begin : g_count
         localparam int PW = $clog2(MAX_PEND + 1);
         localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);
         logic [PW-1:0] pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q <= '0;
            else if (throttled && ref_due) begin
               if (pend_q != PMAX) pend_q <= pend_q + 1'b1;
            end else if (ref_req && ref_ack)
               pend_q <= pend_q - 1'b1;
         end
         assign ref_req = (pend_q != '0) && !throttled;
      end
   endgenerate
endmodule

// File: rtl/act_throttle.sv
module act_throttle
   import act_throttle_pkg::*;
#(
   parameter int WIN_LEN     = 1344,
   parameter int LIM_W       = 8,
   parameter int UNIT        = 4,
   parameter int CKE_LAT     = 2,
   parameter int CKE_MIN_LOW = 3,
   parameter int CKE_HI_LEAD = 3,
   parameter int MAX_PEND    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_strobe,
   input  logic             ref_due,
   input  logic             ref_ack,
   input  logic [1:0]       temp_rng,
   input  logic             gbl_req,
   input  logic             mode_hi,
   input  logic             hunt_en,
   input  logic [LIM_W-1:0] lim_low,
   input  logic [LIM_W-1:0] lim_mid,
   input  logic [LIM_W-1:0] lim_high,
   output logic             act_ok,
   output logic             cke,
   output logic             ref_req,
   output logic [1:0]       stat_lvl,
   output logic             stat_thr,
   output logic             stat_gbl
);
   localparam int POS_W   = $clog2(WIN_LEN);
   localparam int UNIT_SH = $clog2(UNIT);
   localparam int CNT_W   = LIM_W + UNIT_SH;
   localparam int GUARD   = CKE_LAT + CKE_MIN_LOW + CKE_HI_LEAD;

   generate
      if (UNIT != (1 << UNIT_SH)) begin : g_bad_unit
         $error("UNIT must be a power of two");
      end
      if (WIN_LEN <= GUARD + 2) begin : g_bad_win
         $error("WIN_LEN too short for the clock-enable guard");
      end
      if (MAX_PEND < 1) begin : g_bad_pend
         $error("MAX_PEND must be at least 1");
      end
   endgenerate

   logic [POS_W-1:0] win_pos;
   logic             win_last;
   logic [POS_W-1:0] win_rem;
   thr_lvl_e         lvl;
   logic [LIM_W-1:0] sel_lim;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] act_cnt;
   logic             throttled;
   logic             cke_lo_q;
   logic             gbl_q;

   act_thr_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk  (clk),
      .rst_n(rst_n),
      .pos  (win_pos),
      .last (win_last)
   );

   act_thr_level_sel u_sel (
      .temp_rng(temp_rng),
      .gbl_req (gbl_req),
      .mode_hi (mode_hi),
      .hunt_en (hunt_en),
      .lvl     (lvl)
   );

   always_comb begin
      unique case (lvl)
         LVL_HIGH: sel_lim = lim_high;
         LVL_MID:  sel_lim = lim_mid;
         default:  sel_lim = lim_low;
      endcase
   end

   assign limit     = CNT_W'(sel_lim) << UNIT_SH;
   assign throttled = (act_cnt >= limit);
   assign act_ok    = !throttled;
   assign win_rem   = POS_W'(WIN_LEN - 1) - win_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      act_cnt <= '0;
      else if (win_last)               act_cnt <= '0;
      else if (act_strobe && act_ok)   act_cnt <= act_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cke_lo_q <= 1'b0;
      else if (!throttled) cke_lo_q <= 1'b0;
      else if (cke_lo_q)   cke_lo_q <= (win_rem > POS_W'(CKE_HI_LEAD));
      else                 cke_lo_q <= (win_rem >= POS_W'(GUARD));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gbl_q <= 1'b0;
      else        gbl_q <= gbl_req;
   end

   act_thr_refresh #(.MAX_PEND(MAX_PEND)) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .throttled(throttled),
      .ref_due  (ref_due),
      .ref_ack  (ref_ack),
      .ref_req  (ref_req)
   );

   assign cke      = !cke_lo_q;
   assign stat_lvl = lvl;
   assign stat_thr = throttled;
   assign stat_gbl = gbl_q;
endmodule

// File: rtl/act_thr_checker.sv
module act_thr_checker #(
   parameter int WIN_LEN = 1344,
   parameter int CNT_W   = 10,
   parameter int GUARD   = 8,
   localparam int POS_W  = $clog2(WIN_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             act_ok,
   input logic             ref_req,
   input logic [1:0]       stat_lvl,
   input logic [1:0]       temp_rng,
   input logic             mode_hi,
   input logic             hunt_en,
   input logic [POS_W-1:0] win_pos,
   input logic             win_last,
   input logic [CNT_W-1:0] act_cnt
);
   logic [POS_W-1:0] rem;
   assign rem = POS_W'(WIN_LEN - 1) - win_pos;

   assert_cnt_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(win_last) |-> act_cnt == '0);

   assert_cke_high_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rem <= POS_W'(2) |-> cke);

   assert_cke_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> $past(rem) >= POS_W'(GUARD));

   assert_replay_unblocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> act_ok);

   assert_high_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_lvl == 2'd2 |-> hunt_en && mode_hi && temp_rng[1]);

   assert_blocked_not_counted_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ok && !win_last |=> $stable(act_cnt));
endmodule

bind act_throttle act_thr_checker #(
   .WIN_LEN(WIN_LEN),
   .CNT_W  (CNT_W),
   .GUARD  (GUARD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cke     (cke),
   .act_ok  (act_ok),
   .ref_req (ref_req),
   .stat_lvl(stat_lvl),
   .temp_rng(temp_rng),
   .mode_hi (mode_hi),
   .hunt_en (hunt_en),
   .win_pos (win_pos),
   .win_last(win_last),
   .act_cnt (act_cnt)
);

// File: tb/test_act_throttle.sv
module test_act_throttle;
   localparam int W = 1344;
   localparam int G = 8;
   localparam int NWIN = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act_strobe = 0, ref_due = 0, ref_ack = 0, gbl_req = 0, mode_hi = 0, hunt_en = 0;
   logic [1:0] temp_rng = 0;
   logic [7:0] lim_low = 0, lim_mid = 0, lim_high = 0;
   logic act_ok, cke, ref_req, stat_thr, stat_gbl;
   logic [1:0] stat_lvl;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_pos = 0, m_cnt = 0, m_pend = 0;
   bit m_ckelo = 0, m_gblq = 0;

   always #2 clk = ~clk;

   act_throttle i_act_throttle (
      .clk(clk), .rst_n(rst_n), .act_strobe(act_strobe), .ref_due(ref_due),
      .ref_ack(ref_ack), .temp_rng(temp_rng), .gbl_req(gbl_req), .mode_hi(mode_hi),
      .hunt_en(hunt_en), .lim_low(lim_low), .lim_mid(lim_mid), .lim_high(lim_high),
      .act_ok(act_ok), .cke(cke), .ref_req(ref_req), .stat_lvl(stat_lvl),
      .stat_thr(stat_thr), .stat_gbl(stat_gbl)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at window pos %0d: actual %0d expected %0d", req, m_pos, act, exp);
      end
   endtask

   function automatic int sel_lvl(int t, bit g, bit m, bit h);
      if (!h) return g ? 1 : 0;
      if (t >= 2 && m) return 2;
      if (t >= 1 || g) return 1;
      return 0;
   endfunction

   // one cycle: drive at the falling edge, judge, advance the model
   task automatic step(bit s, bit d, bit a);
      int lvl, lim, rem;
      bit thr, rq;
      act_strobe = s; ref_due = d; ref_ack = a;
      #1;
      lvl = sel_lvl(int'(temp_rng), gbl_req, mode_hi, hunt_en);
      lim = 4 * ((lvl == 2) ? int'(lim_high) : (lvl == 1) ? int'(lim_mid) : int'(lim_low));
      thr = (m_cnt >= lim);
      rq  = (m_pend != 0) && !thr;
      rem = W - 1 - m_pos;
      chk(hunt_en ? "R4 level" : "R3 level", int'(stat_lvl), lvl);
      chk("R2 act_ok", int'(act_ok), int'(!thr));
      chk("R11 stat_thr", int'(stat_thr), int'(thr));
      chk(m_ckelo ? "R6 cke" : (rem <= 2 ? "R8 cke" : "R7 cke"), int'(cke), int'(!m_ckelo));
      chk(m_pend != 0 ? "R9 ref_req" : "R10 ref_req", int'(ref_req), int'(rq));
      chk("R5 stat_gbl", int'(stat_gbl), int'(m_gblq));
      // R1 R12: count clears at rollover, blocked strobes do not count
      if (m_pos == W - 1) m_cnt = 0;
      else if (s && !thr) m_cnt++;
      m_ckelo = thr && (m_ckelo ? (rem > 3) : (rem >= G));
      if (thr && d) begin
         if (m_pend < 2) m_pend++;
      end else if (rq && a) m_pend--;
      m_gblq = gbl_req;
      m_pos = (m_pos == W - 1) ? 0 : m_pos + 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0042);
      lim_low = 8'd2;
      repeat (3) @(negedge clk);
      chk("R8 reset cke", int'(cke), 1);
      chk("R9 reset ref_req", int'(ref_req), 0);
      chk("R2 reset act_ok", int'(act_ok), 1);
      rst_n = 1'b1;
      for (int w = 0; w < NWIN; w++) begin
         int kind, s;
         kind = w % 4;
         lim_low = 8'($urandom_range(1, 4));
         lim_mid = 8'($urandom_range(1, 3));
         lim_high = 8'($urandom_range(0, 2));
         temp_rng = 2'($urandom_range(0, 3));
         gbl_req = 1'($urandom_range(0, 1));
         mode_hi = 1'($urandom_range(0, 1));
         hunt_en = 1'($urandom_range(0, 1));
         s = $urandom_range(0, W - 1);
         if (kind == 1) begin
            // R7/R6 guard edge: throttle first seen with remaining G+k
            lim_low = 8'd1; hunt_en = 0; gbl_req = 0;
            s = W - 1 - (G + ((w / 4) % 5 - 2)) - 4;
         end
         if (kind == 3) begin
            // R9: fully blocked window, due on the rollover cycle
            hunt_en = 1; mode_hi = 1; temp_rng = 2'b10; lim_high = 8'd0;
         end
         for (int p = 0; p < W; p++) begin
            bit st, du, ak;
            st = (p >= s) && ($urandom_range(0, 3) != 0);
            du = ($urandom_range(0, 96) == 0);
            ak = 1'($urandom_range(0, 1));
            if (kind == 1) st = (p >= s);
            if (kind == 2) begin
               temp_rng = 2'($urandom_range(0, 3));
               gbl_req = 1'($urandom_range(0, 1));
               if ($urandom_range(0, 63) == 0) hunt_en = ~hunt_en;
               st = 1'($urandom_range(0, 1));
            end
            if (kind == 3) begin
               du = (p == 500) || (p == W - 1);
               ak = 0;
            end
            step(st, du, ak);
         end
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule